// File: doc/BRIEF.md
# Phase-Shifted PWM Channel Output

This block drives one pulse-width-modulated output pin from a phase counter that is shared by many channels. On each clock it takes the counter's position, subtracts the channel's own phase offset modulo 2^16, and compares the result with the duty value. The pin is active while the offset position is below the duty value, so the rising edge can sit anywhere in the cycle and the pulse width is a 16-bit fraction of the cycle.

The comparison precision is chosen at run time by a 4-bit resolution select. A select of n keeps the n+1 most significant bits of both compare operands and clears the rest. The duty and phase offset inputs pass through shadow registers that load only on the cycle-start strobe, so a change made mid-cycle cannot cut a pulse short. A per-channel enable gates the pulse, and an invert bit makes the pin active-low. Modulating the duty value over time is left to logic upstream.

Top module: `pwm_chan_out`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is 0 on the following clock edge, whatever the other inputs are. Reset loads the duty shadow with 0x7FFF and the phase-offset shadow with 0, so with the channel enabled at full resolution and no strobe after reset, phase 0x7FFE gives an active output and phase 0x7FFF an inactive one.
- R2: When `chan_en` is 0, `pwm_out` equals `invert` one clock later. This is the inactive level.
- R3: When `chan_en` is 1, `pwm_out` one clock later equals `act ^ invert`, where `act` is 1 exactly when `((phase - delay_q) mod 2^16) & mask` is less than `duty_q & mask`.
- R4: With `invert` = 1, the output level is the complement of what R3 gives for `invert` = 0. The active level is low.
- R5: `mask` keeps bits 15 down to 15-`res_sel` and clears the lower bits. For example, `res_sel` = 15 gives 0xFFFF, 3 gives 0xF000 and 0 gives 0x8000.
- R6: `duty_q` and `delay_q` load `duty_in` and `delay_in` only at a clock edge where `cycle_start` is 1, and they take effect on the compare from the next clock. Changes to `duty_in` or `delay_in` without a strobe have no effect on `pwm_out`.
- R7: If `duty_q & mask` is 0, the channel stays at its inactive level at every phase.
- R8: The phase offset wraps modulo 2^16. A pulse whose offset lies late in the cycle continues past phase 0xFFFF into the start of the next cycle.
- R9: With duty 0xFFFF at full resolution, the output is active at every offset position except 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 16 | Shared phase counter position |
| cycle_start | input | 1 | Strobe marking the start of a PWM cycle; loads the shadows |
| res_sel | input | 4 | Resolution select; n keeps the top n+1 bits |
| chan_en | input | 1 | Channel enable |
| invert | input | 1 | Polarity invert (1 = active-low) |
| delay_in | input | 16 | Phase offset of the rising edge, in 2^-16 cycle units |
| duty_in | input | 16 | Duty value, in 2^-16 cycle units |
| pwm_out | output | 1 | PWM pin |

## Verification
The case that is hardest to reach from the ports is the shadow boundary. The effect of a duty change must be seen with no strobe and then again after one. The bench first loads a known duty with a strobe. It then moves `duty_in` while holding the strobe low and sets the phase to a point that the new value would make active, and it checks that the pin does not change. It then pulses the strobe and checks that the pin does change. Phase wrap and resolution truncation are reached by choosing phase, offset and duty so that the masked and unmasked comparisons, and the wrapped and unwrapped ones, give opposite answers.

// File: rtl/pwm_chan_pkg.sv
// Package pwm_chan_pkg
// Shared widths and reset constants for the PWM channel output block.
// Assumes a 16-bit phase space and a 4-bit resolution select.
package pwm_chan_pkg;
    localparam int unsigned PHASE_W = 16;
    localparam int unsigned RES_W   = $clog2(PHASE_W);

    typedef logic [PHASE_W-1:0] phase_t;

    // Reset value of the duty shadow: just under half a cycle.
    localparam phase_t DUTY_RESET  = phase_t'({1'b0, {(PHASE_W-1){1'b1}}});
    localparam phase_t DELAY_RESET = '0;
endpackage

// File: rtl/pwm_res_mask.sv
// Module pwm_res_mask
// Turns a logarithmic resolution select into a bit mask that keeps the
// (res_sel+1) most significant bits of a W-bit operand.
// Assumes res_sel never exceeds W-1. Purely combinational.
module pwm_res_mask #(
    parameter int unsigned W     = 16,
    parameter int unsigned RES_W = $clog2(W)
) (
    input  logic [RES_W-1:0] res_sel,
    output logic [W-1:0]     mask
);
    // One comparator per bit: bit i is kept when its distance from the MSB fits the select.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask[i] = (RES_W'(W - 1 - i) <= res_sel);
    end
endmodule

// File: rtl/pwm_shadow.sv
// Module pwm_shadow
// Holds the duty value and phase offset used by the compare. Both load
// only at a clock edge where the cycle-start strobe is high.
// Assumes a synchronous active-low reset.
module pwm_shadow #(
    parameter int unsigned   W         = 16,
    parameter logic [W-1:0]  DUTY_RST  = '0,
    parameter logic [W-1:0]  DELAY_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] duty_in,
    input  logic [W-1:0] delay_in,
    output logic [W-1:0] duty_q,
    output logic [W-1:0] delay_q
);
    // Capture the new cycle's settings on the strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q  <= DUTY_RST;
            delay_q <= DELAY_RST;
        end else if (load) begin
            duty_q  <= duty_in;
            delay_q <= delay_in;
        end
    end
endmodule

// File: rtl/pwm_phase_cmp.sv
// Module pwm_phase_cmp
// Offsets the shared phase by the channel's delay, modulo 2^W, then
// compares the masked result against the masked duty value.
// Assumes mask is a contiguous run of ones from the MSB. Combinational.
module pwm_phase_cmp #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] phase,
    input  logic [W-1:0] delay,
    input  logic [W-1:0] duty,
    input  logic [W-1:0] mask,
    output logic         active
);
    logic [W-1:0] rel_pos;

    // Position within the channel's own shifted cycle, truncated to the resolution.
    always_comb begin
        rel_pos = (phase - delay) & mask;
        active  = rel_pos < (duty & mask);
    end
endmodule

// File: rtl/pwm_chan_out.sv
// Module pwm_chan_out
// One PWM output channel. The duty and offset pass through shadow
// registers loaded on the cycle-start strobe. A masked phase compare sets
// the raw pulse, which is gated by the enable, flipped by the invert bit
// and registered onto the pin.
// Assumes the phase input comes from a shared free-running counter.
module pwm_chan_out
    import pwm_chan_pkg::*;
#(
    parameter int unsigned W     = PHASE_W,
    parameter int unsigned RES_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     phase,
    input  logic             cycle_start,
    input  logic [RES_W-1:0] res_sel,
    input  logic             chan_en,
    input  logic             invert,
    input  logic [W-1:0]     delay_in,
    input  logic [W-1:0]     duty_in,
    output logic             pwm_out
);
    localparam logic [W-1:0] DUTY_RST = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] duty_q;
    logic [W-1:0] delay_q;
    logic [W-1:0] mask;
    logic         active;
    logic         pin_d;

    pwm_shadow #(
        .W(W), .DUTY_RST(DUTY_RST), .DELAY_RST('0)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cycle_start),
        .duty_in  (duty_in),
        .delay_in (delay_in),
        .duty_q   (duty_q),
        .delay_q  (delay_q)
    );

    pwm_res_mask #(.W(W), .RES_W(RES_W)) u_mask (
        .res_sel (res_sel),
        .mask    (mask)
    );

    pwm_phase_cmp #(.W(W)) u_cmp (
        .phase  (phase),
        .delay  (delay_q),
        .duty   (duty_q),
        .mask   (mask),
        .active (active)
    );

    // Gate by enable, then apply polarity.
    always_comb pin_d = (chan_en & active) ^ invert;

    // Register the pin so it never carries compare glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= 1'b0;
        else        pwm_out <= pin_d;
    end
endmodule

// File: rtl/pwm_chan_out_chk.sv
// Module pwm_chan_out_chk
// Property checker for pwm_chan_out, attached by the bind below.
// Observes ports plus the shadow and mask nets of the design.
module pwm_chan_out_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cycle_start,
    input logic         chan_en,
    input logic         invert,
    input logic [W-1:0] duty_in,
    input logic [W-1:0] delay_in,
    input logic [W-1:0] duty_q,
    input logic [W-1:0] delay_q,
    input logic [W-1:0] mask,
    input logic         pwm_out
);
    // R1: reset forces the pin low.
    a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !pwm_out);

    // R2: a disabled channel sits at its inactive level.
    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> pwm_out == $past(invert));

    // R6: shadows hold without a strobe.
    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |=> $stable(duty_q) && $stable(delay_q));

    // R6: shadows take the inputs on a strobe.
    a_r6_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> duty_q == $past(duty_in) && delay_q == $past(delay_in));

    // R7: zero masked duty never activates the pin.
    a_r7_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        ((duty_q & mask) == '0) |=> pwm_out == $past(invert));
endmodule

bind pwm_chan_out pwm_chan_out_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .chan_en     (chan_en),
    .invert      (invert),
    .duty_in     (duty_in),
    .delay_in    (delay_in),
    .duty_q      (duty_q),
    .delay_q     (delay_q),
    .mask        (mask),
    .pwm_out     (pwm_out)
);

// File: tb/pwm_chan_out_tb.sv
module pwm_chan_out_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] phase = '0;
    logic        cycle_start = 1'b0;
    logic [3:0]  res_sel = 4'd15;
    logic        chan_en = 1'b0;
    logic        invert = 1'b0;
    logic [15:0] delay_in = '0;
    logic [15:0] duty_in = '0;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwm_chan_out u_dut (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cycle_start(cycle_start),
        .res_sel(res_sel), .chan_en(chan_en), .invert(invert),
        .delay_in(delay_in), .duty_in(duty_in), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [3:0]  res;
        logic        inv;
        logic        en;
        logic [15:0] dly;
        logic [15:0] dty;
        logic [15:0] ph;
        logic        exp_out;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd15, 1'b0, 1'b1, 16'h0000, 16'h4000, 16'h3FFF, 1'b1},  // R3
        '{4'd15, 1'b0, 1'b1, 16'h0000, 16'h4000, 16'h4000, 1'b0},  // R3
        '{4'd15, 1'b0, 1'b1, 16'h1000, 16'h2000, 16'h0FFF, 1'b0},  // R3/R8
        '{4'd15, 1'b0, 1'b1, 16'h1000, 16'h2000, 16'h1000, 1'b1},  // R3
        '{4'd15, 1'b0, 1'b1, 16'h1000, 16'h2000, 16'h2FFF, 1'b1},  // R3
        '{4'd15, 1'b0, 1'b1, 16'h1000, 16'h2000, 16'h3000, 1'b0},  // R3
        '{4'd15, 1'b0, 1'b1, 16'hF000, 16'h2000, 16'h0800, 1'b1},  // R8
        '{4'd15, 1'b0, 1'b1, 16'hF000, 16'h2000, 16'hE000, 1'b0},  // R8
        '{4'd3,  1'b0, 1'b1, 16'h0000, 16'h1FFF, 16'h0FFF, 1'b1},  // R5
        '{4'd3,  1'b0, 1'b1, 16'h0000, 16'h1FFF, 16'h1000, 1'b0},  // R5
        '{4'd0,  1'b0, 1'b1, 16'h0000, 16'h7FFF, 16'h0000, 1'b0},  // R7
        '{4'd0,  1'b0, 1'b1, 16'h0000, 16'h8000, 16'h7FFF, 1'b1},  // R5
        '{4'd0,  1'b0, 1'b1, 16'h0000, 16'h8000, 16'h8000, 1'b0},  // R5
        '{4'd15, 1'b1, 1'b1, 16'h0000, 16'h4000, 16'h1000, 1'b0},  // R4
        '{4'd15, 1'b1, 1'b1, 16'h0000, 16'h4000, 16'h5000, 1'b1},  // R4
        '{4'd15, 1'b0, 1'b0, 16'h0000, 16'h4000, 16'h1000, 1'b0},  // R2
        '{4'd15, 1'b1, 1'b0, 16'h0000, 16'h4000, 16'h1000, 1'b1},  // R2
        '{4'd15, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 16'hFFFE, 1'b1},  // R9
        '{4'd15, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b0},  // R9
        '{4'd15, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b0}   // R7
    };
    localparam string VTAG [NV] = '{"R3", "R3", "R8", "R3", "R3", "R3", "R8", "R8",
                                    "R5", "R5", "R7", "R5", "R5", "R4", "R4", "R2",
                                    "R2", "R9", "R9", "R7"};

    task automatic check(input string req, input logic act, input logic exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: pwm_out=%b expected %b", req, act, exp_v);
        end
    endtask

    // Load shadows with a strobe, then present the phase and sample one clock later.
    task automatic run_vec(input vec_t v, input string req);
        @(negedge clk);
        duty_in = v.dty; delay_in = v.dly; cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        phase = v.ph; res_sel = v.res; chan_en = v.en; invert = v.inv;
        @(negedge clk);
        check(req, pwm_out, v.exp_out);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: pin low under reset even with invert set.
        invert = 1'b1; chan_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", pwm_out, 1'b0);
        // R1: reset shadow values, no strobe afterwards.
        invert = 1'b0; res_sel = 4'd15; phase = 16'h7FFE;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pwm_out, 1'b1);
        phase = 16'h7FFF;
        @(negedge clk);
        check("R1", pwm_out, 1'b0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], VTAG[i]);

        // R6: duty change without strobe has no effect at the pin.
        run_vec('{4'd15, 1'b0, 1'b1, 16'h0000, 16'h4000, 16'h8000, 1'b0}, "R6");
        duty_in = 16'hFFFF;
        repeat (2) @(negedge clk);
        check("R6", pwm_out, 1'b0);
        delay_in = 16'h8000;
        repeat (2) @(negedge clk);
        check("R6", pwm_out, 1'b0);
        // R6: strobe loads duty 0xFFFF and delay 0x8000; phase 0x8000 gives offset 0.
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        @(negedge clk);
        check("R6", pwm_out, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule